// File: doc/BRIEF.md
# Receive Data Block Demultiplexer

This block sits behind an isochronous receive path. It takes a stream of 32-bit quadlets, one beat per quadlet, in which a last flag marks the final quadlet of each data block. It splits every block into per-channel audio samples and at most one trailing MIDI quadlet. Header parsing, timestamps and sample-rate handling happen elsewhere, so the block sees only the data-block payload.

Each block begins with a configurable number of leading quadlets, which the block throws away. One quadlet per audio channel follows, with channel 0 first. When MIDI ports are configured, one more quadlet follows the audio. Incoming quadlets are big-endian, and the block presents each sample with its bytes reversed into host lane order. A per-channel label mask marks which audio channels carry IEC60958-labelled data. The mask may change while a stream is running. An all-ones stream number switches the stream off. A length check flags any block whose size does not match the configuration.

Top module: `rxblk_demux`

## Requirements
- R1: While `rst` is high, `in_ready`, `out_valid`, `out_midi_valid` and `out_err` are low. `in_ready` goes high at the first clock edge after `rst` is released and then stays high.
- R2: Every output strobe appears exactly one cycle after the accepted quadlet that caused it. Cycles with no accepted quadlet produce no strobe.
- R3: The first `cfg_skip` quadlets of each block produce no output. A skip count of zero is allowed, and the first audio sample is then the first quadlet.
- R4: The next `cfg_chans` quadlets each produce one `out_valid` pulse. `out_chan` runs 0, 1, 2, ... in arrival order.
- R5: When `cfg_midi` is nonzero, the quadlet directly after the audio quadlets produces one `out_midi_valid` pulse, with `out_valid` low. When `cfg_midi` is zero, no MIDI pulse occurs. The two strobes are never high together.
- R6: When `cfg_iso` is all ones (63 at default width), the block still accepts quadlets but drops them. It produces no strobe and no error, and the next quadlet after re-enabling starts a new block.
- R7: `out_label` equals bit `out_chan` of `cfg_label_mask` as it stood when that quadlet was accepted. A mask change between two quadlets applies to the second. `out_label` is low whenever `out_valid` is low.
- R8: With `BYTE_SWAP`=1 (default), `out_data[7:0]` = `in_data[31:24]`, `out_data[15:8]` = `in_data[23:16]`, `out_data[23:16]` = `in_data[15:8]` and `out_data[31:24]` = `in_data[7:0]`.
- R9: If a last quadlet arrives at a count other than skip + channels + (MIDI present ? 1 : 0), `out_err` pulses for one cycle after it. Quadlets beyond the expected length produce no strobe. The following block is parsed from its start.
- R10: Skip, channel and MIDI counts are taken at the first quadlet of a block. Changes made later in the block apply only from the next block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input quadlet present |
| in_ready | output | 1 | Block accepts a quadlet this cycle |
| in_data | input | 32 | Big-endian input quadlet |
| in_last | input | 1 | Quadlet is the last of its data block |
| cfg_skip | input | SKIP_W | Leading quadlets dropped per block |
| cfg_chans | input | CH_W | Audio channel count |
| cfg_midi | input | MIDI_W | MIDI port count (0 = no MIDI quadlet) |
| cfg_iso | input | ISO_W | Stream number; all ones switches the stream off |
| cfg_label_mask | input | MAX_CH | Per-channel IEC60958 label enable |
| out_valid | output | 1 | Audio sample strobe |
| out_midi_valid | output | 1 | MIDI quadlet strobe |
| out_chan | output | CH_IDX_W | Channel index of the audio sample |
| out_data | output | 32 | Sample or MIDI quadlet in host byte order |
| out_label | output | 1 | IEC60958 label for the sample |
| out_err | output | 1 | Block length mismatch pulse |

## Verification
The checker watches several properties on every cycle. It confirms the quiet state under reset and that no strobe or error follows a cycle without an accepted quadlet. It also confirms that the audio and MIDI strobes exclude each other, that the label is only high with an audio strobe, that nothing comes out while the stream is switched off, that each output quadlet is the byte reversal of the accepted one, and that every error follows a last beat. The directed scenarios cover what depends on position within a block: which quadlets are skipped, the channel numbering, where the MIDI quadlet lands, the label values under a changing mask, the short and long length errors with recovery, and the rule that counts are held for the whole block.

// File: rtl/rxblk_pkg.sv
package rxblk_pkg;

  typedef enum logic [1:0] {
    SLOT_SKIP  = 2'd0,
    SLOT_AUDIO = 2'd1,
    SLOT_MIDI  = 2'd2,
    SLOT_EXTRA = 2'd3
  } slot_kind_e;

  // reverse byte lanes: wire order is big-endian, host order is little-endian
  function automatic logic [31:0] quad_byte_rev(input logic [31:0] q);
    return {q[7:0], q[15:8], q[23:16], q[31:24]};
  endfunction

endpackage

// File: rtl/rxblk_pos_track.sv
module rxblk_pos_track #(
  parameter int POS_W  = 10,
  parameter int SKIP_W = 8,
  parameter int CH_W   = 6,
  parameter int MIDI_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              beat,
  input  logic              last,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [CH_W-1:0]   cfg_chans,
  input  logic [MIDI_W-1:0] cfg_midi,
  output logic [POS_W-1:0]  pos,
  output logic [SKIP_W-1:0] eff_skip,
  output logic [CH_W-1:0]   eff_chans,
  output logic              eff_midi_on
);

  logic              first;
  logic [SKIP_W-1:0] lat_skip;
  logic [CH_W-1:0]   lat_chans;
  logic              lat_midi_on;

  assign first = (pos == '0);

  // the first quadlet of a block uses live settings; the rest use the held copy
  always_comb begin
    eff_skip    = first ? cfg_skip    : lat_skip;
    eff_chans   = first ? cfg_chans   : lat_chans;
    eff_midi_on = first ? (|cfg_midi) : lat_midi_on;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pos <= '0;
    end else if (beat) begin
      if (last)
        pos <= '0;
      else if (pos != '1)
        pos <= pos + POS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_skip    <= '0;
      lat_chans   <= '0;
      lat_midi_on <= 1'b0;
    end else if (beat && first) begin
      lat_skip    <= cfg_skip;
      lat_chans   <= cfg_chans;
      lat_midi_on <= |cfg_midi;
    end
  end

endmodule

// File: rtl/rxblk_slot_class.sv
module rxblk_slot_class
  import rxblk_pkg::*;
#(
  parameter int POS_W    = 10,
  parameter int SKIP_W   = 8,
  parameter int CH_W     = 6,
  parameter int CH_IDX_W = 5
) (
  input  logic [POS_W-1:0]    pos,
  input  logic [SKIP_W-1:0]   skip,
  input  logic [CH_W-1:0]     chans,
  input  logic                midi_on,
  output slot_kind_e          kind,
  output logic [CH_IDX_W-1:0] chan,
  output logic [POS_W-1:0]    exp_len
);

  logic [POS_W-1:0] skip_x;
  logic [POS_W-1:0] audio_end;

  always_comb begin
    skip_x    = POS_W'(skip);
    audio_end = skip_x + POS_W'(chans);
    exp_len   = audio_end + POS_W'(midi_on);
    chan      = CH_IDX_W'(pos - skip_x);
    if (pos < skip_x)
      kind = SLOT_SKIP;
    else if (pos < audio_end)
      kind = SLOT_AUDIO;
    else if (midi_on && (pos == audio_end))
      kind = SLOT_MIDI;
    else
      kind = SLOT_EXTRA;
  end

endmodule

// File: rtl/rxblk_out_stage.sv
module rxblk_out_stage
  import rxblk_pkg::*;
#(
  parameter int MAX_CH    = 32,
  parameter int CH_IDX_W  = 5,
  parameter int BYTE_SWAP = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                beat,
  input  logic                last,
  input  logic                mismatch,
  input  slot_kind_e          kind,
  input  logic [CH_IDX_W-1:0] chan,
  input  logic [31:0]         in_data,
  input  logic [MAX_CH-1:0]   label_mask,
  output logic                out_valid,
  output logic                out_midi_valid,
  output logic [CH_IDX_W-1:0] out_chan,
  output logic [31:0]         out_data,
  output logic                out_label,
  output logic                out_err
);

  logic [31:0] data_n;
  logic        is_audio;

  generate
    if (BYTE_SWAP != 0) begin : g_swap
      assign data_n = quad_byte_rev(in_data);
    end else begin : g_pass
      assign data_n = in_data;
    end
  endgenerate

  assign is_audio = (kind == SLOT_AUDIO);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_midi_valid <= 1'b0;
      out_label      <= 1'b0;
      out_err        <= 1'b0;
      out_chan       <= '0;
    end else begin
      out_valid      <= beat && is_audio;
      out_midi_valid <= beat && (kind == SLOT_MIDI);
      out_label      <= beat && is_audio && label_mask[chan];
      out_err        <= beat && last && mismatch;
      if (beat)
        out_chan <= is_audio ? chan : '0;
    end
  end

  // data path carries no reset so it maps onto plain fabric registers
  always_ff @(posedge clk) begin
    if (beat)
      out_data <= data_n;
  end

endmodule

// File: rtl/rxblk_demux.sv
module rxblk_demux
  import rxblk_pkg::*;
#(
  parameter int SKIP_W    = 8,
  parameter int MAX_CH    = 32,
  parameter int MIDI_W    = 4,
  parameter int ISO_W     = 6,
  parameter int BYTE_SWAP = 1,
  parameter int CH_W      = $clog2(MAX_CH + 1),
  parameter int CH_IDX_W  = $clog2(MAX_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_data,
  input  logic                in_last,
  input  logic [SKIP_W-1:0]   cfg_skip,
  input  logic [CH_W-1:0]     cfg_chans,
  input  logic [MIDI_W-1:0]   cfg_midi,
  input  logic [ISO_W-1:0]    cfg_iso,
  input  logic [MAX_CH-1:0]   cfg_label_mask,
  output logic                out_valid,
  output logic                out_midi_valid,
  output logic [CH_IDX_W-1:0] out_chan,
  output logic [31:0]         out_data,
  output logic                out_label,
  output logic                out_err
);

  localparam int POS_W = ((SKIP_W > CH_W) ? SKIP_W : CH_W) + 2;

  logic                rdy_q;
  logic                disabled;
  logic                beat;
  logic [POS_W-1:0]    pos;
  logic [SKIP_W-1:0]   eff_skip;
  logic [CH_W-1:0]     eff_chans;
  logic                eff_midi_on;
  slot_kind_e          kind;
  logic [CH_IDX_W-1:0] chan;
  logic [POS_W-1:0]    exp_len;
  logic                mismatch;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign disabled = (cfg_iso == '1);
  assign beat     = in_valid && rdy_q && !disabled;
  assign mismatch = ({1'b0, pos} + (POS_W+1)'(1)) != {1'b0, exp_len};

  rxblk_pos_track #(
    .POS_W (POS_W),
    .SKIP_W(SKIP_W),
    .CH_W  (CH_W),
    .MIDI_W(MIDI_W)
  ) u_pos (
    .clk        (clk),
    .rst        (rst),
    .clear      (disabled),
    .beat       (beat),
    .last       (in_last),
    .cfg_skip   (cfg_skip),
    .cfg_chans  (cfg_chans),
    .cfg_midi   (cfg_midi),
    .pos        (pos),
    .eff_skip   (eff_skip),
    .eff_chans  (eff_chans),
    .eff_midi_on(eff_midi_on)
  );

  rxblk_slot_class #(
    .POS_W   (POS_W),
    .SKIP_W  (SKIP_W),
    .CH_W    (CH_W),
    .CH_IDX_W(CH_IDX_W)
  ) u_class (
    .pos    (pos),
    .skip   (eff_skip),
    .chans  (eff_chans),
    .midi_on(eff_midi_on),
    .kind   (kind),
    .chan   (chan),
    .exp_len(exp_len)
  );

  rxblk_out_stage #(
    .MAX_CH   (MAX_CH),
    .CH_IDX_W (CH_IDX_W),
    .BYTE_SWAP(BYTE_SWAP)
  ) u_out (
    .clk           (clk),
    .rst           (rst),
    .beat          (beat),
    .last          (in_last),
    .mismatch      (mismatch),
    .kind          (kind),
    .chan          (chan),
    .in_data       (in_data),
    .label_mask    (cfg_label_mask),
    .out_valid     (out_valid),
    .out_midi_valid(out_midi_valid),
    .out_chan      (out_chan),
    .out_data      (out_data),
    .out_label     (out_label),
    .out_err       (out_err)
  );

endmodule

// File: rtl/rxblk_demux_chk.sv
module rxblk_demux_chk #(
  parameter int ISO_W     = 6,
  parameter int BYTE_SWAP = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [31:0]      in_data,
  input logic             in_last,
  input logic [ISO_W-1:0] cfg_iso,
  input logic             out_valid,
  input logic             out_midi_valid,
  input logic [31:0]      out_data,
  input logic             out_label,
  input logic             out_err
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!in_ready && !out_valid && !out_midi_valid && !out_err)); // R1

  AST_NO_BEAT_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> (!out_valid && !out_midi_valid && !out_err)); // R2

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_midi_valid)); // R5

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_iso == '1) |=> (!out_valid && !out_midi_valid && !out_err)); // R6

  AST_LABEL_AUDIO: assert property (@(posedge clk) disable iff (rst)
    out_label |-> out_valid); // R7

  generate
    if (BYTE_SWAP != 0) begin : g_chk_swap
      AST_BYTE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (cfg_iso != '1)) |=>
          (out_data == {$past(in_data[7:0]), $past(in_data[15:8]),
                        $past(in_data[23:16]), $past(in_data[31:24])})); // R8
    end else begin : g_chk_pass
      AST_BYTE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (cfg_iso != '1)) |=>
          (out_data == $past(in_data))); // R8
    end
  endgenerate

  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    out_err |-> $past(in_valid && in_ready && in_last)); // R9

endmodule

bind rxblk_demux rxblk_demux_chk #(
  .ISO_W    (ISO_W),
  .BYTE_SWAP(BYTE_SWAP)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_data       (in_data),
  .in_last       (in_last),
  .cfg_iso       (cfg_iso),
  .out_valid     (out_valid),
  .out_midi_valid(out_midi_valid),
  .out_data      (out_data),
  .out_label     (out_label),
  .out_err       (out_err)
);

// File: tb/rxblk_demux_tb_top.sv
`timescale 1ns/1ps
module rxblk_demux_tb_top;

  localparam int SKIP_W   = 8;
  localparam int MAX_CH   = 32;
  localparam int MIDI_W   = 4;
  localparam int ISO_W    = 6;
  localparam int CH_W     = $clog2(MAX_CH + 1);
  localparam int CH_IDX_W = $clog2(MAX_CH);
  localparam int MAXEV    = 512;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [31:0]         in_data = '0;
  logic                in_last = 1'b0;
  logic [SKIP_W-1:0]   cfg_skip = '0;
  logic [CH_W-1:0]     cfg_chans = '0;
  logic [MIDI_W-1:0]   cfg_midi = '0;
  logic [ISO_W-1:0]    cfg_iso = 6'd5;
  logic [MAX_CH-1:0]   cfg_label_mask = '0;
  logic                out_valid;
  logic                out_midi_valid;
  logic [CH_IDX_W-1:0] out_chan;
  logic [31:0]         out_data;
  logic                out_label;
  logic                out_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] ev_data [MAXEV];
  int          ev_chan [MAXEV];
  bit          ev_lab  [MAXEV];
  bit          ev_midi [MAXEV];
  int          ev_n  = 0;
  int          err_n = 0;

  always #2.5 clk = ~clk;

  rxblk_demux #(
    .SKIP_W(SKIP_W), .MAX_CH(MAX_CH), .MIDI_W(MIDI_W), .ISO_W(ISO_W), .BYTE_SWAP(1)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .cfg_skip(cfg_skip), .cfg_chans(cfg_chans), .cfg_midi(cfg_midi),
    .cfg_iso(cfg_iso), .cfg_label_mask(cfg_label_mask), .out_valid(out_valid),
    .out_midi_valid(out_midi_valid), .out_chan(out_chan), .out_data(out_data),
    .out_label(out_label), .out_err(out_err)
  );

  // event log sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && ev_n < MAXEV) begin
        ev_data[ev_n] = out_data; ev_chan[ev_n] = int'(out_chan);
        ev_lab[ev_n] = out_label; ev_midi[ev_n] = 1'b0; ev_n = ev_n + 1;
      end
      if (out_midi_valid && ev_n < MAXEV) begin
        ev_data[ev_n] = out_data; ev_chan[ev_n] = int'(out_chan);
        ev_lab[ev_n] = out_label; ev_midi[ev_n] = 1'b1; ev_n = ev_n + 1;
      end
      if (out_err) err_n = err_n + 1;
    end
  end

  function automatic logic [31:0] rev(input logic [31:0] q);
    return {q[7:0], q[15:8], q[23:16], q[31:24]};
  endfunction

  function automatic logic [31:0] pat(input int blk, input int i);
    return {8'(blk), 8'(i), 8'hC3, 8'(8'h10 + i)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int k, input bit midi,
                        input int ch, input logic [31:0] d, input bit lab);
    if (k >= ev_n) begin
      chk(1'b0, req, "event missing", 32'(ev_n), 32'(k + 1));
    end else begin
      chk(ev_midi[k] == midi, req, "strobe kind", 32'(ev_midi[k]), 32'(midi));
      chk(ev_chan[k] == ch, req, "channel", 32'(ev_chan[k]), 32'(ch));
      chk(ev_data[k] == d, req, "data", ev_data[k], d);
      chk(ev_lab[k] == lab, req, "label", 32'(ev_lab[k]), 32'(lab));
    end
  endtask

  task automatic beat(input logic [31:0] d, input bit l);
    @(negedge clk); in_valid = 1'b1; in_data = d; in_last = l;
  endtask

  task automatic beat_m(input logic [31:0] d, input bit l, input logic [MAX_CH-1:0] m);
    @(negedge clk); in_valid = 1'b1; in_data = d; in_last = l; cfg_label_mask = m;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    end
  endtask

  task automatic send(input int blk, input int n);
    for (int i = 0; i < n; i++) beat(pat(blk, i), i == n - 1);
    idle(3);
  endtask

  task automatic set_cfg(input int s, input int c, input int m);
    cfg_skip = SKIP_W'(s); cfg_chans = CH_W'(c); cfg_midi = MIDI_W'(m);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!in_ready && !out_valid && !out_midi_valid && !out_err, "R1",
        "quiet in reset", {in_ready, out_valid, out_midi_valid, out_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 1);
    chk(!out_valid && !out_err, "R1", "no strobe after reset", {out_valid, out_err}, 0);
  endtask

  task automatic t_basic;
    int st = ev_n; int es = err_n;
    idle(5);
    chk(ev_n == st, "R2", "no output while idle", 32'(ev_n - st), 0);
    set_cfg(2, 4, 0); cfg_label_mask = 32'h5;
    send(1, 6);
    chk(ev_n - st == 4, "R3", "skip dropped, audio count", 32'(ev_n - st), 4);
    for (int c = 0; c < 4; c++)
      chk_ev("R4", st + c, 1'b0, c, rev(pat(1, c + 2)), (c % 2) == 0);
    chk(err_n == es, "R9", "no error on exact length", 32'(err_n - es), 0);
  endtask

  task automatic t_midi;
    int st = ev_n; int es = err_n;
    set_cfg(0, 3, 2); cfg_label_mask = '1;
    send(2, 4);
    chk(ev_n - st == 4, "R5", "audio plus midi count", 32'(ev_n - st), 4);
    for (int c = 0; c < 3; c++) chk_ev("R3", st + c, 1'b0, c, rev(pat(2, c)), 1'b1);
    chk_ev("R5", st + 3, 1'b1, 0, rev(pat(2, 3)), 1'b0);
    st = ev_n;
    set_cfg(0, 3, 0);
    send(3, 3);
    chk(ev_n - st == 3, "R5", "no midi slot at zero ports", 32'(ev_n - st), 3);
    for (int c = 0; c < 3; c++) chk_ev("R5", st + c, 1'b0, c, rev(pat(3, c)), 1'b1);
    chk(err_n == es, "R9", "no error", 32'(err_n - es), 0);
  endtask

  task automatic t_short_long;
    int st = ev_n; int es = err_n;
    set_cfg(1, 4, 1); cfg_label_mask = '0;
    send(4, 4);
    chk(ev_n - st == 3, "R9", "short block events", 32'(ev_n - st), 3);
    chk(err_n - es == 1, "R9", "short block error", 32'(err_n - es), 1);
    st = ev_n; es = err_n;
    send(5, 6);
    chk(ev_n - st == 5, "R9", "recovery events", 32'(ev_n - st), 5);
    for (int c = 0; c < 4; c++) chk_ev("R9", st + c, 1'b0, c, rev(pat(5, c + 1)), 1'b0);
    chk_ev("R9", st + 4, 1'b1, 0, rev(pat(5, 5)), 1'b0);
    chk(err_n == es, "R9", "recovery no error", 32'(err_n - es), 0);
    st = ev_n;
    set_cfg(0, 2, 0);
    send(6, 5);
    chk(ev_n - st == 2, "R9", "extra quadlets dropped", 32'(ev_n - st), 2);
    chk(err_n - es == 1, "R9", "long block error", 32'(err_n - es), 1);
  endtask

  task automatic t_disabled;
    int st = ev_n; int es = err_n;
    set_cfg(0, 3, 0);
    cfg_iso = '1;
    send(7, 4);
    chk(ev_n == st, "R6", "disabled: no output", 32'(ev_n - st), 0);
    chk(err_n == es, "R6", "disabled: no error", 32'(err_n - es), 0);
    cfg_iso = 6'd5;
    beat(pat(8, 0), 1'b0);
    beat(pat(8, 1), 1'b0);
    idle(2);
    cfg_iso = '1;
    beat(pat(8, 2), 1'b0);
    idle(2);
    cfg_iso = 6'd5;
    st = ev_n;
    send(9, 3);
    chk(ev_n - st == 3, "R6", "restart after disable", 32'(ev_n - st), 3);
    for (int c = 0; c < 3; c++) chk_ev("R6", st + c, 1'b0, c, rev(pat(9, c)), 1'b0);
    chk(err_n == es, "R6", "no error after restart", 32'(err_n - es), 0);
  endtask

  task automatic t_mask;
    int st = ev_n;
    set_cfg(0, 4, 0);
    beat_m(pat(10, 0), 1'b0, 32'hF);
    beat_m(pat(10, 1), 1'b0, 32'h0);
    beat_m(pat(10, 2), 1'b0, 32'h4);
    beat_m(pat(10, 3), 1'b1, 32'h0);
    idle(3);
    chk(ev_n - st == 4, "R7", "mask block count", 32'(ev_n - st), 4);
    for (int c = 0; c < 4; c++)
      chk_ev("R7", st + c, 1'b0, c, rev(pat(10, c)), (c % 2) == 0);
  endtask

  task automatic t_latch;
    int st = ev_n; int es = err_n;
    set_cfg(0, 2, 0);
    beat(pat(11, 0), 1'b0);
    @(negedge clk);
    in_valid = 1'b1; in_data = pat(11, 1); in_last = 1'b1;
    set_cfg(3, 5, 1);
    idle(3);
    chk(ev_n - st == 2, "R10", "held counts for block", 32'(ev_n - st), 2);
    chk_ev("R10", st + 1, 1'b0, 1, rev(pat(11, 1)), 1'b0);
    chk(err_n == es, "R10", "no error from mid-block change", 32'(err_n - es), 0);
    st = ev_n;
    send(12, 9);
    chk(ev_n - st == 6, "R10", "new counts next block", 32'(ev_n - st), 6);
    chk_ev("R10", st, 1'b0, 0, rev(pat(12, 3)), 1'b0);
    chk_ev("R10", st + 5, 1'b1, 0, rev(pat(12, 8)), 1'b0);
    chk(err_n == es, "R10", "no error next block", 32'(err_n - es), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_midi();
    t_short_long();
    t_disabled();
    t_mask();
    t_latch();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule